// File: doc/BRIEF.md
# Selectable-Tone Buzzer Driver

This block drives a piezo buzzer with a square wave at one of eight tones. The tones come from the system clock. A prescaler first divides the clock down to a tone tick, nominally 40 kHz. An integer period counter then divides that tick by a per-tone count. The tick is one prescaler parameter, so the same RTL serves any system clock that is an integer multiple of the tick rate.

The tone can be started in two ways. The first is a direct enable bit. The second is an automatic path armed by a separate bit: while the meter is in continuity or diode mode, an active-low short-detect comparator input makes the buzzer sound on its own.

A tone change waits for the current output period to finish, so no runt pulse is produced. When the buzzer goes silent, the output drops low and the divider chain restarts from zero. The next beep therefore always begins with a full high half-period.

Top module: `buzzer_tone_gen`

## Requirements
- R1: `toneSel` code 0..7 selects a period of 40, 30, 20, 18, 15, 13, 12 and 10 ticks respectively (1.00, 1.33, 2.00, 2.22, 2.67, 3.08, 3.33 and 4.00 kHz at a 40 kHz tick). One tick is `TICK_DIV` clock cycles.
- R2: `buzOut` is low during reset and low whenever the buzzer is not sounding.
- R3: `beepEn` = 1 sounds the buzzer, whatever the values of `modeSel`, `autoBeepEn` and `shortN`.
- R4: With `autoBeepEn` = 1, `shortN` = 0 sounds the buzzer in continuity mode (`modeSel` = 1) or diode mode (`modeSel` = 2). No automatic sound occurs when `autoBeepEn` = 0 or `shortN` = 1.
- R5: With `modeSel` = 0 or 3, `shortN` has no effect on `buzOut`.
- R6: A change of `toneSel` while sounding takes effect only at the next period boundary; the period in progress completes with the old tone.
- R7: A sound request that rises before a clock edge drives `buzOut` high right after that edge, starting a fresh period. A request that falls before a clock edge drives `buzOut` low right after that edge and restarts the divider.
- R8: Each period starts high. The high part lasts ceil(N/2) ticks and the low part floor(N/2) ticks, where N is the tone's period in ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| toneSel | input | 3 | Tone code 0..7 |
| beepEn | input | 1 | Direct buzzer enable |
| autoBeepEn | input | 1 | Arms the short-detect automatic beep |
| shortN | input | 1 | Short-detect comparator, active low |
| modeSel | input | 2 | Meter mode: 1 continuity, 2 diode, 0/3 other |
| buzOut | output | 1 | Square-wave buzzer drive, low when silent |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the sampling edge. They also assume that `toneSel` only reaches the period counter through the boundary latch, so a new code never shortens a period already running. The bench drives each input on the falling clock edge and reads `buzOut` on the next falling edge, so a change always meets a full cycle before the rising edge that registers it. Tone changes are deliberately made in the middle of a high phase, to show that the running period is not disturbed.

// File: rtl/buzz_pkg.sv
`timescale 1ns/1ps
package buzz_pkg;

  localparam int TONE_W = 3;
  localparam int PER_W  = 6;

  typedef logic [TONE_W-1:0] toneCode_t;
  typedef logic [PER_W-1:0]  tickCount_t;

  typedef enum logic [1:0] {
    MODE_OTHER = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_DIODE = 2'd2,
    MODE_SPARE = 2'd3
  } modeCode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       run;
    tickCount_t lastTick;
    tickCount_t highTicks;
  } dpCtrl_t;

  // period of each tone, in 40 kHz ticks
  function automatic tickCount_t tonePeriod(input toneCode_t code);
    tickCount_t per;
    case (code)
      3'd0:    per = 6'd40;
      3'd1:    per = 6'd30;
      3'd2:    per = 6'd20;
      3'd3:    per = 6'd18;
      3'd4:    per = 6'd15;
      3'd5:    per = 6'd13;
      3'd6:    per = 6'd12;
      default: per = 6'd10;
    endcase
    return per;
  endfunction

endpackage

// File: rtl/tone_ctrl.sv
`timescale 1ns/1ps
module tone_ctrl
  import buzz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  toneCode_t  toneSel,
  input  logic       beepEn,
  input  logic       autoBeepEn,
  input  logic       shortN,
  input  logic [1:0] modeSel,
  input  logic       wrap,
  output dpCtrl_t    strb,
  output toneCode_t  activeTone
);

  localparam tickCount_t ONE = tickCount_t'(1);

  logic       shortMode;
  logic       soundReq;
  logic       soundReg;
  tickCount_t period;

  assign shortMode = (modeSel == MODE_CONT) || (modeSel == MODE_DIODE);
  assign soundReq  = beepEn | (autoBeepEn & ~shortN & shortMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      soundReg   <= 1'b0;
      activeTone <= '0;
    end else begin
      soundReg <= soundReq;
      // tone may only move while idle or on a period boundary
      if (!soundReg || wrap) activeTone <= toneSel;
    end
  end

  always_comb begin
    period         = tonePeriod(activeTone);
    strb.run       = soundReg;
    strb.lastTick  = period - ONE;
    strb.highTicks = (period + ONE) >> 1;
  end

endmodule

// File: rtl/tone_datapath.sv
`timescale 1ns/1ps
module tone_datapath
  import buzz_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t strb,
  output logic    wrap,
  output logic    buzOut
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam tickCount_t ONE = tickCount_t'(1);

  logic       tickEv;
  tickCount_t tickCnt;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           preCnt <= '0;
        else if (!strb.run)  preCnt <= '0;
        else if (preCnt == PRE_LAST) preCnt <= '0;
        else                 preCnt <= preCnt + 1'b1;
      end
      assign tickEv = (preCnt == PRE_LAST);
    end else begin : g_nopre
      assign tickEv = 1'b1;
    end
  endgenerate

  assign wrap = strb.run & tickEv & (tickCnt == strb.lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tickCnt <= '0;
    else if (!strb.run) tickCnt <= '0;
    else if (tickEv) begin
      if (tickCnt == strb.lastTick) tickCnt <= '0;
      else                          tickCnt <= tickCnt + ONE;
    end
  end

  assign buzOut = strb.run & (tickCnt < strb.highTicks);

endmodule

// File: rtl/buzzer_tone_gen.sv
`timescale 1ns/1ps
module buzzer_tone_gen
  import buzz_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] toneSel,
  input  logic       beepEn,
  input  logic       autoBeepEn,
  input  logic       shortN,
  input  logic [1:0] modeSel,
  output logic       buzOut
);

  dpCtrl_t   dpStrb;
  logic      wrapStrb;
  toneCode_t activeTone;

  tone_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .toneSel    (toneSel),
    .beepEn     (beepEn),
    .autoBeepEn (autoBeepEn),
    .shortN     (shortN),
    .modeSel    (modeSel),
    .wrap       (wrapStrb),
    .strb       (dpStrb),
    .activeTone (activeTone)
  );

  tone_datapath #(.TICK_DIV(TICK_DIV)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (dpStrb),
    .wrap   (wrapStrb),
    .buzOut (buzOut)
  );

endmodule

// File: rtl/buzzer_tone_gen_chk.sv
`timescale 1ns/1ps
module buzzer_tone_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       beepEn,
  input logic       autoBeepEn,
  input logic       shortN,
  input logic [1:0] modeSel,
  input logic       buzOut,
  input logic       run,
  input logic       wrap,
  input logic [2:0] activeTone
);

  logic inShortMode;
  logic autoReq;
  logic anyReq;

  assign inShortMode = (modeSel == 2'd1) || (modeSel == 2'd2);
  assign autoReq     = autoBeepEn && !shortN && inShortMode;
  assign anyReq      = beepEn || autoReq;

  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> !buzOut); // R2

  AST_DIRECT_EN: assert property (@(posedge clk) disable iff (!rstN)
    beepEn |=> run); // R3

  AST_AUTO_EN: assert property (@(posedge clk) disable iff (!rstN)
    autoReq |=> run); // R4

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!beepEn && !inShortMode) |=> !buzOut); // R5

  AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (run && !wrap) |=> $stable(activeTone)); // R6

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyReq) |=> buzOut); // R7

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wrap |-> !buzOut); // R8

  AST_OUT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    buzOut |-> run); // R2

endmodule

bind buzzer_tone_gen buzzer_tone_gen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .beepEn     (beepEn),
  .autoBeepEn (autoBeepEn),
  .shortN     (shortN),
  .modeSel    (modeSel),
  .buzOut     (buzOut),
  .run        (dpStrb.run),
  .wrap       (wrapStrb),
  .activeTone (activeTone)
);

// File: tb/buzzer_tone_gen_bench.sv
`timescale 1ns/1ps
module buzzer_tone_gen_bench;

  localparam int TICK_DIV = 4;
  localparam int LIMIT    = 1000;

  // tone code, high ticks, low ticks (R1, R8)
  localparam int VEC [8][3] = '{
    '{0, 20, 20}, '{1, 15, 15}, '{2, 10, 10}, '{3, 9, 9},
    '{4,  8,  7}, '{5,  7,  6}, '{6,  6,  6}, '{7, 5, 5}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] toneSel = 3'd0;
  logic       beepEn = 1'b0;
  logic       autoBeepEn = 1'b0;
  logic       shortN = 1'b1;
  logic [1:0] modeSel = 2'd0;
  logic       buzOut;

  int checks = 0;
  int errors = 0;
  int hiCnt;
  int loCnt;

  always #2.5 clk = ~clk;

  buzzer_tone_gen #(.TICK_DIV(TICK_DIV)) u_buzzer_tone_gen (
    .clk(clk), .rstN(rstN), .toneSel(toneSel), .beepEn(beepEn),
    .autoBeepEn(autoBeepEn), .shortN(shortN), .modeSel(modeSel),
    .buzOut(buzOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // from a negedge where buzOut just went high: count high then low samples
  task automatic measure();
    hiCnt = 0;
    loCnt = 0;
    while (buzOut && hiCnt < LIMIT) begin hiCnt++; @(negedge clk); end
    while (!buzOut && loCnt < LIMIT) begin loCnt++; @(negedge clk); end
  endtask

  task automatic expectSilent(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (buzOut) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic stopAll();
    beepEn = 1'b0; autoBeepEn = 1'b0; shortN = 1'b1; modeSel = 2'd0;
    @(negedge clk);
    check("R2 low after stop", int'(buzOut), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=200000 cycles expected=fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state (R2)
    repeat (3) @(negedge clk);
    check("R2 low in reset", int'(buzOut), 0);
    rstN = 1'b1;
    expectSilent(10, "R2 idle after reset");

    // table walk: every tone through the direct enable (R1, R3, R8)
    for (int v = 0; v < 8; v++) begin
      toneSel = 3'(VEC[v][0]);
      beepEn  = 1'b1;
      @(negedge clk);
      check("R7 high one cycle after request", int'(buzOut), 1);
      measure();
      check("R1 R8 high cycles", hiCnt, VEC[v][1] * TICK_DIV);
      check("R1 R8 low cycles", loCnt, VEC[v][2] * TICK_DIV);
      stopAll();
    end

    // tone change lands at the boundary (R6)
    toneSel = 3'd0; beepEn = 1'b1;
    @(negedge clk);
    toneSel = 3'd7;
    measure();
    check("R6 old tone high kept", hiCnt, 20 * TICK_DIV);
    check("R6 old tone low kept", loCnt, 20 * TICK_DIV);
    measure();
    check("R6 new tone high", hiCnt, 5 * TICK_DIV);
    check("R6 new tone low", loCnt, 5 * TICK_DIV);
    stopAll();

    // disable mid-high, then fresh period (R7)
    toneSel = 3'd2; beepEn = 1'b1;
    repeat (10) @(negedge clk);
    beepEn = 1'b0;
    @(negedge clk);
    check("R7 low right after drop", int'(buzOut), 0);
    repeat (3) @(negedge clk);
    beepEn = 1'b1;
    @(negedge clk);
    measure();
    check("R7 divider restarted high", hiCnt, 10 * TICK_DIV);
    check("R7 divider restarted low", loCnt, 10 * TICK_DIV);
    stopAll();

    // automatic beep in continuity and diode modes (R4)
    toneSel = 3'd7; autoBeepEn = 1'b1; shortN = 1'b0; modeSel = 2'd1;
    @(negedge clk);
    measure();
    check("R4 continuity auto high", hiCnt, 5 * TICK_DIV);
    check("R4 continuity auto low", loCnt, 5 * TICK_DIV);
    stopAll();
    toneSel = 3'd6; autoBeepEn = 1'b1; shortN = 1'b0; modeSel = 2'd2;
    @(negedge clk);
    measure();
    check("R4 diode auto high", hiCnt, 6 * TICK_DIV);
    check("R4 diode auto low", loCnt, 6 * TICK_DIV);
    shortN = 1'b1;
    @(negedge clk);
    check("R4 short released low", int'(buzOut), 0);
    stopAll();

    // auto path not armed, or comparator idle (R4)
    autoBeepEn = 1'b0; shortN = 1'b0; modeSel = 2'd1;
    expectSilent(100, "R4 unarmed silent");
    autoBeepEn = 1'b1; shortN = 1'b1; modeSel = 2'd2;
    expectSilent(100, "R4 no short silent");

    // short-detect ignored outside continuity/diode (R5)
    autoBeepEn = 1'b1; shortN = 1'b0; modeSel = 2'd0;
    expectSilent(100, "R5 mode 0 ignores short");
    modeSel = 2'd3;
    expectSilent(100, "R5 mode 3 ignores short");

    // direct enable works in any mode (R3)
    beepEn = 1'b1; toneSel = 3'd7;
    @(negedge clk);
    check("R3 direct enable in mode 3", int'(buzOut), 1);
    stopAll();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule